// File: doc/BRIEF.md
# Overcurrent Hiccup Retry Controller

This block supervises one regulated output using a digital overload indication from an analog comparator. While its enable bit is set, it drives an output-enable line and watches the overload signal. That signal is brought into the clock domain through a synchroniser and then has to stay high for a set number of cycles before it counts as a real overload.

The mode bit picks between two ways of handling a qualified overload. With the mode bit low, the output is cut for a long off period. It is then switched back on for a short trial window. The overload is checked once, at the last cycle of that window. If it is still present, the off period starts again, and this repeats for as long as the fault stays. If it has gone, normal running resumes. With the mode bit high, the analog path limits the current. The controller keeps the output on and only reports the overload.

A read-only flag reports the fault: it is high through every off period and trial window, and whenever a qualified overload is present. All durations are parameters counted in clock cycles. This lets simulation use short values, while a real build uses the full 900 ms off and 20 ms trial lengths at its clock rate.

Top module: `ocp_hiccup_ctrl`

## Requirements
- R1: During reset and in the first cycle after it, `drive_en_o` and `ovl_flag_o` are both 0.
- R2: When `out_en_i` is low at a clock edge, `drive_en_o` is 0 after that edge, whatever the state. Both timers restart, and the next assertion of `out_en_i` sets `drive_en_o` to 1 one edge later.
- R3: A change on `ovl_raw_i` passes through SYNC_STAGES flops and must then hold for QUAL_CYCLES consecutive cycles before it counts as a qualified overload. A high pulse shorter than QUAL_CYCLES cycles has no effect on either output.
- R4: With `static_mode_i` = 0 (hiccup mode) and the output running, a qualified overload clears `drive_en_o` on the next edge and sets `ovl_flag_o`.
- R5: The off period lasts exactly OFF_CYCLES cycles. After it, `drive_en_o` returns to 1 for the trial window.
- R6: The trial window lasts exactly TRIAL_CYCLES cycles with `drive_en_o` = 1. The overload is only examined in its final cycle; an overload that appears and clears inside the window does not cut the output.
- R7: If a qualified overload is present in the final trial cycle, the off period starts again. This repeats without limit.
- R8: If no qualified overload is present in the final trial cycle, normal running resumes and `ovl_flag_o` drops to 0.
- R9: With `static_mode_i` = 1 and `out_en_i` = 1, `drive_en_o` is 1 one edge later and stays 1. `ovl_flag_o` equals the qualified overload.
- R10: Raising `static_mode_i` during an off period or trial window returns the controller to normal running on the next edge, with `drive_en_o` = 1.
- R11: `ovl_flag_o` is 1 throughout every off period and trial window.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| out_en_i | input | 1 | Output enable bit; low forces shutdown and idle |
| static_mode_i | input | 1 | 0 selects hiccup retry, 1 selects report-only (static limiting) |
| ovl_raw_i | input | 1 | Asynchronous overload comparator output |
| drive_en_o | output | 1 | Enable drive to the regulator stage |
| ovl_flag_o | output | 1 | Read-only overload flag |

## Verification
The properties assume that the mode bit and the enable bit are quasi-static register bits that change synchronously with the clock. They also assume the off period is never cut short except by the enable bit or the mode bit, which is why the off-length check disarms on either of them. The comparator input is treated as asynchronous and is qualified internally. The stimulus changes all inputs only on falling edges. It holds each input pattern for a whole number of cycles chosen from the synchroniser, qualifier and timer lengths, so every sample lands on a settled cycle of a known state.

// File: rtl/ocp_pkg.sv
package ocp_pkg;

    // Controller states: idle (disabled), running, forced off, trial on
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_RUN   = 2'd1,
        ST_OFF   = 2'd2,
        ST_TRIAL = 2'd3
    } hic_state_e;

    // Decoded outputs of the state register
    typedef struct packed {
        logic drive;
        logic in_fault;
        logic use_off_len;
    } hic_ctrl_t;

    // Width needed to hold values 0..n
    function automatic int unsigned cnt_width(input int unsigned n);
        int unsigned w;
        w = 1;
        while ((64'd1 << w) <= 64'(n)) w++;
        return w;
    endfunction

    function automatic hic_ctrl_t decode_state(input hic_state_e s);
        hic_ctrl_t c;
        c.drive       = (s == ST_RUN) || (s == ST_TRIAL);
        c.in_fault    = (s == ST_OFF) || (s == ST_TRIAL);
        c.use_off_len = (s == ST_OFF);
        return c;
    endfunction

endpackage

// File: rtl/ocp_sync.sv
module ocp_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain[0] <= 1'b0;
                    else     chain[0] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain[i] <= 1'b0;
                    else     chain[i] <= chain[i-1];
                end
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/ocp_qualify.sv
module ocp_qualify #(
    parameter int unsigned HOLD = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic lvl,
    output logic det
);
    localparam int unsigned CW = ocp_pkg::cnt_width(HOLD);
    localparam logic [CW-1:0] HOLD_L = CW'(HOLD);

    logic [CW-1:0] run_cnt;

    always_ff @(posedge clk) begin
        if (rst || !lvl)           run_cnt <= '0;
        else if (run_cnt != HOLD_L) run_cnt <= run_cnt + 1'b1;
    end

    assign det = (run_cnt == HOLD_L);
endmodule

// File: rtl/ocp_interval_timer.sv
module ocp_interval_timer #(
    parameter int unsigned LONG_LEN  = 1000,
    parameter int unsigned SHORT_LEN = 100
) (
    input  logic clk,
    input  logic rst,
    input  logic restart,
    input  logic use_long,
    output logic expire
);
    localparam int unsigned MAXLEN = (LONG_LEN > SHORT_LEN) ? LONG_LEN : SHORT_LEN;
    localparam int unsigned TW     = ocp_pkg::cnt_width(MAXLEN);
    localparam logic [TW-1:0] LAST_LONG  = TW'(LONG_LEN - 1);
    localparam logic [TW-1:0] LAST_SHORT = TW'(SHORT_LEN - 1);

    logic [TW-1:0] elapsed;
    logic [TW-1:0] last;

    assign last   = use_long ? LAST_LONG : LAST_SHORT;
    assign expire = (elapsed == last);

    always_ff @(posedge clk) begin
        if (rst || restart) elapsed <= '0;
        else if (!expire)   elapsed <= elapsed + 1'b1;
    end
endmodule

// File: rtl/ocp_hiccup_fsm.sv
module ocp_hiccup_fsm
    import ocp_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic enable,
    input  logic static_mode,
    input  logic ovl_det,
    input  logic tmr_expire,
    output logic tmr_restart,
    output logic tmr_use_long,
    output logic drive,
    output logic flag
);
    hic_state_e state_q, state_d;
    hic_ctrl_t  ctrl;

    always_comb begin
        state_d = state_q;
        if (!enable) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE:  state_d = ST_RUN;
                ST_RUN:   if (!static_mode && ovl_det) state_d = ST_OFF;
                ST_OFF: begin
                    if (static_mode)     state_d = ST_RUN;
                    else if (tmr_expire) state_d = ST_TRIAL;
                end
                ST_TRIAL: begin
                    if (static_mode)     state_d = ST_RUN;
                    else if (tmr_expire) state_d = ovl_det ? ST_OFF : ST_RUN;
                end
                default:  state_d = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    assign ctrl         = decode_state(state_q);
    assign tmr_restart  = (state_d != state_q);
    assign tmr_use_long = ctrl.use_off_len;
    assign drive        = ctrl.drive;
    assign flag         = ctrl.in_fault || ovl_det;
endmodule

// File: rtl/ocp_hiccup_ctrl.sv
module ocp_hiccup_ctrl #(
    parameter int unsigned SYNC_STAGES  = 2,
    parameter int unsigned QUAL_CYCLES  = 4,
    parameter int unsigned OFF_CYCLES   = 45_000_000,
    parameter int unsigned TRIAL_CYCLES = 1_000_000
) (
    input  logic clk,
    input  logic rst,
    input  logic out_en_i,
    input  logic static_mode_i,
    input  logic ovl_raw_i,
    output logic drive_en_o,
    output logic ovl_flag_o
);
    logic ovl_sync;
    logic ovl_det;
    logic tmr_restart;
    logic tmr_use_long;
    logic tmr_expire;

    ocp_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (ovl_raw_i),
        .q   (ovl_sync)
    );

    ocp_qualify #(.HOLD(QUAL_CYCLES)) u_qual (
        .clk (clk),
        .rst (rst),
        .lvl (ovl_sync),
        .det (ovl_det)
    );

    ocp_interval_timer #(
        .LONG_LEN  (OFF_CYCLES),
        .SHORT_LEN (TRIAL_CYCLES)
    ) u_tmr (
        .clk      (clk),
        .rst      (rst),
        .restart  (tmr_restart),
        .use_long (tmr_use_long),
        .expire   (tmr_expire)
    );

    ocp_hiccup_fsm u_fsm (
        .clk          (clk),
        .rst          (rst),
        .enable       (out_en_i),
        .static_mode  (static_mode_i),
        .ovl_det      (ovl_det),
        .tmr_expire   (tmr_expire),
        .tmr_restart  (tmr_restart),
        .tmr_use_long (tmr_use_long),
        .drive        (drive_en_o),
        .flag         (ovl_flag_o)
    );
endmodule

// File: rtl/ocp_hiccup_chk.sv
module ocp_hiccup_chk #(
    parameter int unsigned OFF_CYCLES = 40
) (
    input logic clk,
    input logic rst,
    input logic out_en_i,
    input logic static_mode_i,
    input logic drive_en_o,
    input logic ovl_flag_o
);
    logic        drv_q, en_q, st_q;
    logic        armed;
    int unsigned off_cnt;

    // Measures the length of a fault-driven off period
    always_ff @(posedge clk) begin
        if (rst) begin
            drv_q   <= 1'b0;
            en_q    <= 1'b0;
            st_q    <= 1'b0;
            armed   <= 1'b0;
            off_cnt <= 0;
        end else begin
            drv_q <= drive_en_o;
            en_q  <= out_en_i;
            st_q  <= static_mode_i;
            if (drv_q && !drive_en_o && en_q && !st_q && out_en_i && !static_mode_i) begin
                armed   <= 1'b1;
                off_cnt <= 1;
            end else if (!out_en_i || static_mode_i || drive_en_o) begin
                armed <= 1'b0;
            end else if (armed) begin
                off_cnt <= off_cnt + 1;
            end
        end
    end

    p_disable_off_r2: assert property (@(posedge clk) disable iff (rst)
        !out_en_i |=> !drive_en_o);

    p_static_on_r9: assert property (@(posedge clk) disable iff (rst)
        (out_en_i && static_mode_i) |=> drive_en_o);

    p_flag_in_off_r11: assert property (@(posedge clk) disable iff (rst)
        (!drive_en_o && out_en_i && $past(out_en_i) && !$past(rst)) |-> ovl_flag_o);

    p_off_length_r5: assert property (@(posedge clk) disable iff (rst)
        ($rose(drive_en_o) && armed) |-> (off_cnt == OFF_CYCLES));

endmodule

bind ocp_hiccup_ctrl ocp_hiccup_chk #(.OFF_CYCLES(OFF_CYCLES)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .out_en_i      (out_en_i),
    .static_mode_i (static_mode_i),
    .drive_en_o    (drive_en_o),
    .ovl_flag_o    (ovl_flag_o)
);

// File: tb/test_ocp_hiccup_ctrl.sv
module test_ocp_hiccup_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int QUAL  = 3;
    localparam int OFFC  = 40;
    localparam int TRIAL = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic en = 1'b0, st = 1'b0, ov = 1'b0;
    logic drv, flg;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;

    ocp_hiccup_ctrl #(
        .SYNC_STAGES  (2),
        .QUAL_CYCLES  (QUAL),
        .OFF_CYCLES   (OFFC),
        .TRIAL_CYCLES (TRIAL)
    ) i_ocp_hiccup_ctrl (
        .clk           (clk),
        .rst           (rst),
        .out_en_i      (en),
        .static_mode_i (st),
        .ovl_raw_i     (ov),
        .drive_en_o    (drv),
        .ovl_flag_o    (flg)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    typedef struct packed {
        logic en;
        logic st;
        logic ov;
        int   n;
        logic drv;
        logic flg;
        int   req;
    } vec_t;

    // Latency: overload visible after 2 sync + QUAL edges = 5, off at edge 6
    localparam vec_t VEC [29] = '{
        '{1'b0,1'b0,1'b0, 3,     1'b0,1'b0, 1},  // R1 idle after reset
        '{1'b1,1'b0,1'b0, 1,     1'b1,1'b0, 2},  // R2 enable drives
        '{1'b1,1'b0,1'b1, 4,     1'b1,1'b0, 3},  // R3 not yet qualified
        '{1'b1,1'b0,1'b1, 1,     1'b1,1'b1, 3},  // R3 qualified
        '{1'b1,1'b0,1'b1, 1,     1'b0,1'b1, 4},  // R4 cut on next edge
        '{1'b1,1'b0,1'b0, OFFC-2,1'b0,1'b1, 5},  // R5 still off
        '{1'b1,1'b0,1'b0, 2,     1'b1,1'b1, 5},  // R5 trial starts
        '{1'b1,1'b0,1'b0, TRIAL-1,1'b1,1'b1,6},  // R6 trial last cycle
        '{1'b1,1'b0,1'b0, 1,     1'b1,1'b0, 8},  // R8 clean end
        '{1'b1,1'b0,1'b1, 6,     1'b0,1'b1, 4},  // R4 second fault
        '{1'b1,1'b0,1'b1, OFFC,  1'b1,1'b1, 5},  // R5 trial
        '{1'b1,1'b0,1'b1, TRIAL, 1'b0,1'b1, 7},  // R7 re-enter off
        '{1'b1,1'b0,1'b1, OFFC,  1'b1,1'b1, 7},  // R7 repeats
        '{1'b1,1'b0,1'b0, TRIAL, 1'b1,1'b0, 8},  // R8 recovers
        '{1'b0,1'b0,1'b0, 1,     1'b0,1'b0, 2},  // R2 disable
        '{1'b1,1'b1,1'b1, 10,    1'b1,1'b1, 9},  // R9 static reports
        '{1'b1,1'b1,1'b0, 5,     1'b1,1'b0, 9},  // R9 static clears
        '{1'b1,1'b0,1'b1, 6,     1'b0,1'b1, 4},  // R4 hiccup again
        '{1'b0,1'b0,1'b0, 4,     1'b0,1'b0, 2},  // R2 disable during off
        '{1'b1,1'b0,1'b0, 1,     1'b1,1'b0, 2},  // R2 re-enable
        '{1'b1,1'b0,1'b1, 6,     1'b0,1'b1, 4},  // R4
        '{1'b1,1'b0,1'b0, 20,    1'b0,1'b1, 11}, // R11 flag held in off
        '{1'b0,1'b0,1'b0, 1,     1'b0,1'b0, 2},  // R2 disable mid-off
        '{1'b1,1'b0,1'b1, 6,     1'b0,1'b1, 4},  // R4 fresh off
        '{1'b1,1'b0,1'b0, OFFC-1,1'b0,1'b1, 5},  // R5 full length restarted
        '{1'b1,1'b0,1'b0, 1,     1'b1,1'b1, 6},  // R6 trial
        '{1'b1,1'b0,1'b0, TRIAL, 1'b1,1'b0, 8},  // R8
        '{1'b1,1'b0,1'b1, 6,     1'b0,1'b1, 4},  // R4
        '{1'b1,1'b1,1'b1, 1,     1'b1,1'b1, 10}  // R10 static exits off
    };

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(input logic got_d, input logic got_f,
                         input logic exp_d, input logic exp_f, input int req);
        checks++;
        if (got_d !== exp_d || got_f !== exp_f) begin
            errors++;
            $display("FAIL R%0d: drive=%b flag=%b expected drive=%b flag=%b",
                     req, got_d, got_f, exp_d, exp_f);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        tick(100000);
        errors++;
        checks++;
        $display("FAIL watchdog: run did not complete, expected completion");
        finish_run();
    end

    initial begin
        logic ok;
        // R1: reset state
        tick(3);
        check(drv, flg, 1'b0, 1'b0, 1);
        rst = 1'b0;
        tick(1);
        check(drv, flg, 1'b0, 1'b0, 1); // R1 first cycle after reset

        for (int i = 0; i < 29; i++) begin
            en = VEC[i].en;
            st = VEC[i].st;
            ov = VEC[i].ov;
            tick(VEC[i].n);
            check(drv, flg, VEC[i].drv, VEC[i].flg, VEC[i].req);
        end

        // R1: reset while static with overload present
        rst = 1'b1;
        tick(2);
        check(drv, flg, 1'b0, 1'b0, 1);
        en = 1'b0; st = 1'b0; ov = 1'b0;
        tick(1);
        rst = 1'b0;
        en  = 1'b1;
        tick(1);
        check(drv, flg, 1'b1, 1'b0, 2); // R2 enable after reset

        // R3: pulse shorter than the qualify length is ignored
        ok = 1'b1;
        ov = 1'b1;
        tick(2);
        ov = 1'b0;
        for (int k = 0; k < 8; k++) begin
            tick(1);
            if (drv !== 1'b1 || flg !== 1'b0) ok = 1'b0;
        end
        check(ok, 1'b0, 1'b1, 1'b0, 3);

        // R6: a fault inside the trial window does not cut the output
        ov = 1'b1;
        tick(6);
        check(drv, flg, 1'b0, 1'b1, 4);
        ov = 1'b0;
        tick(OFFC);
        check(drv, flg, 1'b1, 1'b1, 5);
        ok = 1'b1;
        ov = 1'b1;
        for (int k = 0; k < 3; k++) begin
            tick(1);
            if (drv !== 1'b1) ok = 1'b0;
        end
        ov = 1'b0;
        for (int k = 0; k < 5; k++) begin
            tick(1);
            if (drv !== 1'b1) ok = 1'b0;
        end
        check(ok, 1'b0, 1'b1, 1'b0, 6);
        check(drv, flg, 1'b1, 1'b0, 8); // R8 window ended clean

        finish_run();
    end
endmodule